// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Core

This core runs a single operation and nothing else. Each instruction word names two data locations and gives the upper bits of the next instruction address. The core reads the value at the first location, then the value at the second. It subtracts the first value from the second and stores the difference back at the second location. The sign of the difference is appended as the least significant bit of the next instruction address, which is how a program branches.

The core has no incrementing program counter. Code written for it sequences itself entirely through the partial next addresses it carries. The top bit of the 5-bit instruction address selects one of two interleaved programs. A program hands control to the other one by choosing that bit in its partial address.

The instruction and data memories sit outside the core. Each is accessed through a synchronous port that does one read or one write per clock. Read data returns on the cycle after the request. Data width is a parameter and may be as small as one bit. Wider arithmetic is built in software from sequences of narrow steps.

Top module: `subneg_core`

## Requirements
- R1: While rst_ni is low, the instruction address is 0, an instruction fetch is requested at address 0, and no data write or write-back pulse occurs.
- R2: Every instruction takes exactly five cycles, in this order: instruction fetch, read of operand A, read of operand B, execute, write-back. An instruction read is requested only in the fetch cycle.
- R3: No cycle carries both a data read and a data write, and at most one data access is made per cycle.
- R4: In the write-back cycle, the core writes the value (mem[B] - mem[A]) modulo 2^DATA_W to address B, and to no other address.
- R5: The next instruction address is the partial address with the sign bit of the written difference appended as its LSB. The sign bit is 1 when the MSB of the difference is 1.
- R6: The instruction address changes only at write-back. Its MSB comes only from the partial address, so a program switches task only through the code it runs.
- R7: The instruction word holds operand A address in bits [IW-1:IW-DADDR_W], operand B address in the next DADDR_W bits down, and the partial next address in bits [IADDR_W-2:0].
- R8: dbg_wb_o is high for exactly one cycle per instruction, in the cycle the data write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_rd_o | output | 1 | Instruction read request |
| imem_addr_o | output | IADDR_W | Instruction address |
| imem_rdata_i | input | IW | Instruction word, valid the cycle after the request |
| dmem_rd_o | output | 1 | Data read request |
| dmem_wr_o | output | 1 | Data write request |
| dmem_addr_o | output | DADDR_W | Data address |
| dmem_wdata_o | output | DATA_W | Data to write |
| dmem_rdata_i | input | DATA_W | Read data, valid the cycle after the request |
| dbg_pc_o | output | IADDR_W | Current full instruction address |
| dbg_wb_o | output | 1 | One-cycle pulse at write-back |

## Verification
Counted from the fetch request, the instruction word arrives one cycle later. The operand A read goes out in that same cycle and the operand B read one cycle after it. The write of the difference is due four cycles after the fetch, and the new instruction address appears five cycles after it. The reference model in the bench steps through the same five-phase schedule. At each falling edge it compares every memory request, address, write value and debug output against the value expected for that phase. The data it uses comes from its own copy of memory, which it updates at each write-back.

// File: rtl/subneg_pkg.sv
package subneg_pkg;
  typedef enum logic [2:0] {
    ST_IF = 3'd0,
    ST_RA = 3'd1,
    ST_RB = 3'd2,
    ST_EX = 3'd3,
    ST_WB = 3'd4
  } phase_e;
endpackage

// File: rtl/subneg_ctrl.sv
module subneg_ctrl
  import subneg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e state_o
);
  phase_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      ST_IF:   state_d = ST_RA;
      ST_RA:   state_d = ST_RB;
      ST_RB:   state_d = ST_EX;
      ST_EX:   state_d = ST_WB;
      default: state_d = ST_IF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_ex_then_wb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EX |=> state_q == ST_WB);
  assert_wb_then_if_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WB |=> state_q == ST_IF);
endmodule

// File: rtl/subneg_alu.sv
module subneg_alu #(
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_a_i,
  input  logic              ld_d_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] diff_o,
  output logic              neg_o
);
  logic [DATA_W-1:0] opa_q, diff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      diff_q <= '0;
    end else begin
      if (ld_a_i) opa_q  <= rdata_i;
      if (ld_d_i) diff_q <= rdata_i - opa_q;
    end
  end

  assign diff_o = diff_q;
  assign neg_o  = diff_q[DATA_W-1];

  assert_diff_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_d_i |=> $stable(diff_q));
endmodule

// File: rtl/subneg_pc.sv
module subneg_pc #(
  parameter int IADDR_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [IADDR_W-2:0] part_i,
  input  logic               neg_i,
  output logic [IADDR_W-1:0] pc_o
);
  logic [IADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (upd_i) pc_q <= {part_i, neg_i};
  end

  assign pc_o = pc_q;

  assert_pc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(pc_q));
endmodule

// File: rtl/subneg_core.sv
module subneg_core
  import subneg_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int DADDR_W = 4,
  parameter int IADDR_W = 5,
  localparam int PART_W = IADDR_W - 1,
  localparam int IW     = 2 * DADDR_W + PART_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic               imem_rd_o,
  output logic [IADDR_W-1:0] imem_addr_o,
  input  logic [IW-1:0]      imem_rdata_i,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o,
  output logic [DADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  input  logic [DATA_W-1:0]  dmem_rdata_i,
  output logic [IADDR_W-1:0] dbg_pc_o,
  output logic               dbg_wb_o
);
  phase_e             state;
  logic [DADDR_W-1:0] a_live, b_q;
  logic [PART_W-1:0]  part_q;
  logic [DATA_W-1:0]  diff;
  logic               neg;
  logic [IADDR_W-1:0] pc;

  subneg_ctrl u_ctrl (.clk_i(clk_i), .rst_ni(rst_ni), .state_o(state));

  assign a_live = imem_rdata_i[IW-1 -: DADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q    <= '0;
      part_q <= '0;
    end else if (state == ST_RA) begin
      b_q    <= imem_rdata_i[IW-DADDR_W-1 -: DADDR_W];
      part_q <= imem_rdata_i[PART_W-1:0];
    end
  end

  subneg_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ld_a_i(state == ST_RB), .ld_d_i(state == ST_EX),
    .rdata_i(dmem_rdata_i), .diff_o(diff), .neg_o(neg)
  );

  subneg_pc #(.IADDR_W(IADDR_W)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(state == ST_WB), .part_i(part_q), .neg_i(neg), .pc_o(pc)
  );

  assign imem_rd_o    = (state == ST_IF);
  assign imem_addr_o  = pc;
  assign dmem_rd_o    = (state == ST_RA) || (state == ST_RB);
  assign dmem_wr_o    = (state == ST_WB);
  assign dmem_addr_o  = (state == ST_RA) ? a_live : b_q;
  assign dmem_wdata_o = diff;
  assign dbg_pc_o     = pc;
  assign dbg_wb_o     = (state == ST_WB);

  assert_one_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_rd_o && dmem_wr_o));
  assert_wr_to_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_wr_o |-> dmem_addr_o == $past(dmem_addr_o, 2));
  assert_sign_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wb_o |=> dbg_pc_o[0] == $past(dmem_wdata_o[DATA_W-1]));
  assert_single_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_rd_o |=> !imem_rd_o);
  assert_wb_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wb_o |=> !dbg_wb_o);
endmodule

// File: tb/subneg_core_test.sv
module subneg_core_test;
  localparam int DW = 4, DAW = 4, IAW = 5, PW = IAW - 1, IW = 2 * DAW + PW;
  localparam int RUN = 2000;

  logic clk = 0, rst_ni = 0;
  logic imem_rd, dmem_rd, dmem_wr, dbg_wb;
  logic [IAW-1:0] imem_addr, dbg_pc;
  logic [IW-1:0]  irdata;
  logic [DAW-1:0] dmem_addr;
  logic [DW-1:0]  wdata, drdata;

  logic [IW-1:0] prog [32];
  logic [DW-1:0] mem [16];
  logic [DW-1:0] ref_mem [16];

  int checks = 0, fails = 0, wbs = 0;
  int seen_zero = 0, seen_neg = 0, seen_wrap = 0, seen_swap = 0;
  int phase = 0;
  logic [IAW-1:0] ref_pc = '0;
  logic [IW-1:0]  cur;
  bit done = 0;

  always #4 clk = ~clk;

  subneg_core uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_rd_o(imem_rd), .imem_addr_o(imem_addr), .imem_rdata_i(irdata),
    .dmem_rd_o(dmem_rd), .dmem_wr_o(dmem_wr), .dmem_addr_o(dmem_addr),
    .dmem_wdata_o(wdata), .dmem_rdata_i(drdata),
    .dbg_pc_o(dbg_pc), .dbg_wb_o(dbg_wb)
  );

  always @(posedge clk) begin
    if (imem_rd) irdata <= prog[imem_addr];
    if (dmem_rd) drdata <= mem[dmem_addr];
    if (dmem_wr) mem[dmem_addr] <= wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle reference model (fields per R7)
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [DAW-1:0] fa, fb;
      logic [DW-1:0]  res;
      fa = cur[IW-1 -: DAW];
      fb = cur[IW-DAW-1 -: DAW];
      chk(dbg_pc == ref_pc, "R6 pc", dbg_pc, ref_pc);
      chk(!(dmem_rd && dmem_wr), "R3 access", {dmem_rd, dmem_wr}, 0);
      chk(imem_rd == (phase == 0), "R2 fetch", imem_rd, phase == 0);
      chk(dbg_wb == (phase == 4), "R8 pulse", dbg_wb, phase == 4);
      case (phase)
        0: begin
          chk(imem_addr == ref_pc, "R2 fetch addr", imem_addr, ref_pc);
          chk(!dmem_rd && !dmem_wr, "R3 idle", {dmem_rd, dmem_wr}, 0);
          cur = prog[ref_pc];
        end
        1: chk(dmem_rd && !dmem_wr && dmem_addr == fa, "R2 read A (R7)", dmem_addr, fa);
        2: chk(dmem_rd && !dmem_wr && dmem_addr == fb, "R2 read B (R7)", dmem_addr, fb);
        3: chk(!dmem_rd && !dmem_wr, "R2 execute", {dmem_rd, dmem_wr}, 0);
        default: begin
          res = ref_mem[fb] - ref_mem[fa];
          chk(dmem_wr && dmem_addr == fb, "R4 wr addr", dmem_addr, fb);
          chk(wdata == res, "R4 diff", wdata, res);
          if (res == 0) seen_zero++;
          if (res[DW-1]) seen_neg++;
          if (ref_mem[fb][DW-1] && !ref_mem[fa][DW-1] && !res[DW-1]) seen_wrap++;
          ref_mem[fb] = res;
          if (ref_pc[IAW-1] != cur[PW-1]) seen_swap++;
          ref_pc = {cur[PW-1:0], res[DW-1]};
          wbs++;
        end
      endcase
      phase = (phase == 4) ? 0 : phase + 1;
    end
  end

  initial begin
    int unsigned s;
    s = 32'h1234_5678;
    for (int i = 0; i < 32; i++) begin
      s = s * 1664525 + 1013904223;
      prog[i] = s[27:16];
    end
    for (int i = 0; i < 16; i++) begin
      s = s * 1664525 + 1013904223;
      mem[i] = s[19:16];
    end
    // directed: equal operands -> zero -> switch to task 1 (pc 16)
    prog[0] = {4'd1, 4'd2, 4'b1000};
    mem[1] = 4'd3; mem[2] = 4'd3;
    // directed: most negative minus one wraps to +7 -> non-negative -> pc 0
    prog[16] = {4'd3, 4'd4, 4'b0000};
    mem[3] = 4'd1; mem[4] = 4'd8;
    for (int i = 0; i < 16; i++) ref_mem[i] = mem[i];

    repeat (3) @(negedge clk);
    chk(dbg_pc == 0, "R1 pc", dbg_pc, 0);
    chk(imem_rd && imem_addr == 0, "R1 fetch", imem_addr, 0);
    chk(!dmem_wr && !dbg_wb, "R1 no write", {dmem_wr, dbg_wb}, 0);
    @(posedge clk); #1 rst_ni = 1;
    repeat (RUN) @(posedge clk);
    #1 done = 1;
    chk(wbs == RUN / 5, "R2 rate", wbs, RUN / 5);
    chk(seen_zero > 0, "R5 zero result", seen_zero, 1);
    chk(seen_neg > 0, "R5 negative result", seen_neg, 1);
    chk(seen_wrap > 0, "R4 wraparound", seen_wrap, 1);
    chk(seen_swap > 0, "R6 task switch", seen_swap, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule